// File: doc/BRIEF.md
# Block-Refill Memory Timing Model

This block stands in for the main memory behind a cache during a block refill. A refill request carries a block address. The block then returns the four words of that block after a delay that matches one of three memory organizations, chosen by a parameter:

- **Narrow:** one word per access, with the accesses made one after another.
- **Wide:** four words per access, returned in a single beat.
- **Interleaved:** four banks read together, then the words sent out one per cycle.

The latency is built from three parameters:

- the address cycles, paid once per refill;
- the access cost, paid once for each storage access started;
- the transfer cost, paid once for each hand-over to the cache.

With the default values the refill takes 65, 17 or 20 cycles.

The storage is one dual-port RAM per word lane. Each lane is indexed by block number, so an FPGA flow can map it to block RAM. A single-word write port fills the storage while the block is idle. A cache model or a performance bench uses the block to see the stall each organization causes.

Top module: `refill_top`

## Requirements
- R1: After synchronous reset, busy, done, rd_valid and beat_valid are all low.
- R2: A request (req_valid high while busy is low) is taken at that clock edge. busy is high from the next cycle through the cycle in which done is high, and low in the cycle after that.
- R3: A request made while busy is high has no effect: the refill in progress is unchanged, and no second refill follows it.
- R4: Narrow organization (ORG=0): word k (k = 0..3) appears on the cycle 1+16(k+1) after acceptance, and done is high on cycle 65.
- R5: Interleaved organization (ORG=2): word k appears on cycle 17+k after acceptance, and done is high on cycle 20.
- R6: Wide organization (ORG=1): one beat appears on cycle 17 after acceptance with done high. Word k of the block occupies beat_data bits [32k+31:32k].
- R7: Words leave in ascending offset order starting at 0, with rd_idx carrying the offset. The final word is the one delivered with done.
- R8: Word k of block b carries the storage word written at wr_addr = 4b+k.
- R9: A write (wr_en high) while busy is low stores wr_data at wr_addr. A write while busy is high is ignored.
- R10: With ORG=1, rd_valid never rises. With ORG=0 or ORG=2, beat_valid never rises.
- R11: done is high for exactly one cycle per refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request |
| req_blk | input | BLK_W | Block number to refill |
| wr_en | input | 1 | Single-word write strobe |
| wr_addr | input | BLK_W+2 | Word address of the write: block number followed by word offset |
| wr_data | input | WORD_W | Write data |
| busy | output | 1 | Refill in progress |
| rd_valid | output | 1 | One word valid (narrow and interleaved) |
| rd_idx | output | 2 | Word offset of rd_data |
| rd_data | output | WORD_W | Returned word |
| beat_valid | output | 1 | Whole block valid (wide) |
| beat_data | output | 4*WORD_W | Whole block, word 0 in the low bits |
| done | output | 1 | Last transfer of the refill |

## Verification
The bench runs the three organizations side by side on the same stimulus and checks every cycle of each refill against word arrival times computed from the latency formula. A counter that is one cycle off would move done and every word strobe, and the cycle-exact comparison catches that. A request is injected in the middle of a refill; a design that accepted it would start a second refill or restart the first. A write is also made during a refill; a design that honoured it would return corrupted data on the next read of that block. Word order, the lane-to-bit placement in the wide beat, and the release of busy one cycle after done are each checked, so a swapped lane or a busy that falls early cannot go unseen.

// File: rtl/refill_pkg.sv
`timescale 1ns/1ps
package refill_pkg;
  typedef enum logic [1:0] {
    ORG_NARROW     = 2'd0,
    ORG_WIDE       = 2'd1,
    ORG_INTERLEAVE = 2'd2
  } org_e;

  // Total refill latency in cycles, from acceptance to done.
  function automatic int unsigned refill_cycles(org_e org, int unsigned words,
                                                int unsigned a, int unsigned c,
                                                int unsigned x);
    case (org)
      ORG_NARROW: return a + words * (c + x);
      ORG_WIDE:   return a + c + x;
      default:    return a + c + words * x;
    endcase
  endfunction
endpackage

// File: rtl/refill_bank.sv
`timescale 1ns/1ps
module refill_bank #(
  parameter int DATA_W  = 32,
  parameter int DEPTH_W = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic [DEPTH_W-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DEPTH_W-1:0] raddr,
  output logic [DATA_W-1:0]  rdata
);
  localparam int DEPTH = 1 << DEPTH_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/refill_seq.sv
`timescale 1ns/1ps
module refill_seq
  import refill_pkg::*;
#(
  parameter org_e ORG        = ORG_NARROW,
  parameter int   WORDS      = 4,
  parameter int   ADDR_CYC   = 1,
  parameter int   ACCESS_CYC = 15,
  parameter int   XFER_CYC   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             fire,
  output logic             last,
  output logic [$clog2(WORDS)-1:0] widx
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int MAXC  = (ACCESS_CYC > ADDR_CYC) ?
                         ((ACCESS_CYC > XFER_CYC) ? ACCESS_CYC : XFER_CYC) :
                         ((ADDR_CYC > XFER_CYC) ? ADDR_CYC : XFER_CYC);
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] ADDR_LD = CNT_W'(ADDR_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] XFER_LD = CNT_W'(XFER_CYC - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_ACC, S_XFER} st_e;

  st_e              state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign fire     = (state == S_XFER) && cnt_zero;

  generate
    if (ORG == ORG_WIDE) begin : g_one_beat
      assign last = 1'b1;
    end else begin : g_per_word
      assign last = (idx == LAST_IDX);
    end
  endgenerate

  assign widx = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_ADDR;
          cnt   <= ADDR_LD;
          idx   <= '0;
        end
        S_ADDR: if (cnt_zero) begin
          state <= S_ACC;
          cnt   <= ACC_LD;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_ACC: if (cnt_zero) begin
          state <= S_XFER;
          cnt   <= XFER_LD;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_XFER: if (cnt_zero) begin
          if (last) begin
            state <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
            if (ORG == ORG_NARROW) begin
              state <= S_ACC;
              cnt   <= ACC_LD;
            end else begin
              cnt <= XFER_LD;
            end
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refill_top.sv
`timescale 1ns/1ps
module refill_top
  import refill_pkg::*;
#(
  parameter org_e ORG        = ORG_NARROW,
  parameter int   WORD_W     = 32,
  parameter int   BLK_W      = 4,
  parameter int   ADDR_CYC   = 1,
  parameter int   ACCESS_CYC = 15,
  parameter int   XFER_CYC   = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [BLK_W-1:0]    req_blk,
  input  logic                wr_en,
  input  logic [BLK_W+1:0]    wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  output logic                busy,
  output logic                rd_valid,
  output logic [1:0]          rd_idx,
  output logic [WORD_W-1:0]   rd_data,
  output logic                beat_valid,
  output logic [4*WORD_W-1:0] beat_data,
  output logic                done
);
  localparam int WORDS = 4;
  localparam int IDX_W = $clog2(WORDS);

  logic                  start;
  logic                  fire;
  logic                  last;
  logic [IDX_W-1:0]      widx;
  logic [BLK_W-1:0]      blk_q;
  logic [WORD_W-1:0]     lane_q [WORDS];
  logic [WORDS*WORD_W-1:0] beat_next;
  logic                  wr_ok;

  assign start = req_valid && !busy;
  assign wr_ok = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (rst)        blk_q <= '0;
    else if (start) blk_q <= req_blk;
  end

  generate
    for (genvar k = 0; k < WORDS; k++) begin : g_lane
      refill_bank #(
        .DATA_W (WORD_W),
        .DEPTH_W(BLK_W)
      ) u_bank (
        .clk  (clk),
        .we   (wr_ok && (wr_addr[IDX_W-1:0] == IDX_W'(k))),
        .waddr(wr_addr[BLK_W+IDX_W-1:IDX_W]),
        .wdata(wr_data),
        .raddr(blk_q),
        .rdata(lane_q[k])
      );
      assign beat_next[k*WORD_W +: WORD_W] = lane_q[k];
    end
  endgenerate

  refill_seq #(
    .ORG       (ORG),
    .WORDS     (WORDS),
    .ADDR_CYC  (ADDR_CYC),
    .ACCESS_CYC(ACCESS_CYC),
    .XFER_CYC  (XFER_CYC)
  ) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .fire (fire),
    .last (last),
    .widx (widx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      rd_valid   <= 1'b0;
      beat_valid <= 1'b0;
      done       <= 1'b0;
      rd_idx     <= '0;
      rd_data    <= '0;
      beat_data  <= '0;
    end else begin
      if (start)     busy <= 1'b1;
      else if (done) busy <= 1'b0;
      rd_valid   <= fire && (ORG != ORG_WIDE);
      beat_valid <= fire && (ORG == ORG_WIDE);
      done       <= fire && last;
      if (fire && ORG != ORG_WIDE) begin
        rd_idx  <= widx;
        rd_data <= lane_q[widx];
      end
      if (fire && ORG == ORG_WIDE) beat_data <= beat_next;
    end
  end
endmodule

// File: rtl/refill_chk.sv
`timescale 1ns/1ps
module refill_chk
  import refill_pkg::*;
#(
  parameter org_e ORG        = ORG_NARROW,
  parameter int   ADDR_CYC   = 1,
  parameter int   ACCESS_CYC = 15,
  parameter int   XFER_CYC   = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       busy,
  input logic       rd_valid,
  input logic [1:0] rd_idx,
  input logic       beat_valid,
  input logic       done
);
  localparam int unsigned LAT = refill_cycles(ORG, 4, ADDR_CYC, ACCESS_CYC, XFER_CYC);

  logic [15:0] since_acc;
  logic [1:0]  wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_acc <= '0;
      wcnt      <= '0;
    end else if (req_valid && !busy) begin
      since_acc <= '0;
      wcnt      <= '0;
    end else begin
      if (busy) since_acc <= since_acc + 16'd1;
      if (rd_valid) wcnt <= wcnt + 2'd1;
    end
  end

  a_r2_busy_set: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);
  a_r2_busy_drop: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  a_r3_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4, R5, R6: done lands exactly LAT cycles after acceptance
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy && since_acc == 16'(LAT)));
  a_r7_order: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_idx == wcnt));
  a_r10_strobe: assert property (@(posedge clk) disable iff (rst)
    (ORG == ORG_WIDE) ? !rd_valid : !beat_valid);
endmodule

bind refill_top refill_chk #(
  .ORG       (ORG),
  .ADDR_CYC  (ADDR_CYC),
  .ACCESS_CYC(ACCESS_CYC),
  .XFER_CYC  (XFER_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .rd_idx    (rd_idx),
  .beat_valid(beat_valid),
  .done      (done)
);

// File: tb/sim_refill_top.sv
`timescale 1ns/1ps
module sim_refill_top;
  import refill_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst;
  logic         req_valid;
  logic [3:0]   req_blk;
  logic         wr_en;
  logic [5:0]   wr_addr;
  logic [31:0]  wr_data;

  logic         busy_w [3];
  logic         rv_w   [3];
  logic [1:0]   idx_w  [3];
  logic [31:0]  rd_w   [3];
  logic         bv_w   [3];
  logic [127:0] beat_w [3];
  logic         done_w [3];

  logic [31:0] model [64];
  int checks = 0;
  int errors = 0;

  refill_top #(.ORG(ORG_NARROW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_blk(req_blk),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy_w[0]), .rd_valid(rv_w[0]), .rd_idx(idx_w[0]), .rd_data(rd_w[0]),
    .beat_valid(bv_w[0]), .beat_data(beat_w[0]), .done(done_w[0]));
  refill_top #(.ORG(ORG_WIDE)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_blk(req_blk),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy_w[1]), .rd_valid(rv_w[1]), .rd_idx(idx_w[1]), .rd_data(rd_w[1]),
    .beat_valid(bv_w[1]), .beat_data(beat_w[1]), .done(done_w[1]));
  refill_top #(.ORG(ORG_INTERLEAVE)) u2 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_blk(req_blk),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy_w[2]), .rd_valid(rv_w[2]), .rd_idx(idx_w[2]), .rd_data(rd_w[2]),
    .beat_valid(bv_w[2]), .beat_data(beat_w[2]), .done(done_w[2]));

  // Arrival cycle of word k after acceptance; instance 0 narrow, 1 wide, 2 interleaved.
  function automatic int word_time(int org, int k);
    case (org)
      0:       return 1 + (k + 1) * (15 + 1);
      1:       return 1 + 15 + 1;
      default: return 1 + 15 + (k + 1);
    endcase
  endfunction

  function automatic int lat_of(int org);
    return word_time(org, 3);
  endfunction

  function automatic string lat_tag(int org);
    case (org)
      0:       return "R4";
      1:       return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic write_word(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  // One refill on all three instances, checked cycle by cycle.
  task automatic refill(input logic [3:0] blk, input bit inject, input string dtag);
    bit   ok_lat [3], ok_busy [3], ok_str [3], ok_data [3];
    int   done_n [3];
    logic [127:0] bad_act [3], bad_exp [3];
    for (int i = 0; i < 3; i++) begin
      ok_lat[i] = 1; ok_busy[i] = 1; ok_str[i] = 1; ok_data[i] = 1;
      done_n[i] = -1; bad_act[i] = '0; bad_exp[i] = '0;
    end
    @(negedge clk);
    req_valid = 1'b1; req_blk = blk;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= 70; n++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        int L = lat_of(i);
        bit erv = 0;
        int ek = 0;
        logic [127:0] eb;
        for (int k = 0; k < 4; k++)
          if (i != 1 && word_time(i, k) == n) begin erv = 1; ek = k; end
        if (done_w[i] && done_n[i] < 0) done_n[i] = n;
        if (done_w[i] != (n == L)) ok_lat[i] = 0;
        if (busy_w[i] != (n <= L)) ok_busy[i] = 0;
        if (rv_w[i] != erv || bv_w[i] != (i == 1 && n == L)) ok_str[i] = 0;
        if (erv && (idx_w[i] != 2'(ek) || rd_w[i] != model[{blk, 2'(ek)}])) begin
          if (ok_data[i]) begin bad_act[i] = {94'd0, idx_w[i], rd_w[i]};
            bad_exp[i] = {94'd0, 2'(ek), model[{blk, 2'(ek)}]}; end
          ok_data[i] = 0;
        end
        if (i == 1 && n == L) begin
          for (int k = 0; k < 4; k++) eb[k*32 +: 32] = model[{blk, 2'(k)}];
          if (beat_w[i] != eb) begin
            ok_data[i] = 0; bad_act[i] = beat_w[i]; bad_exp[i] = eb;
          end
        end
      end
      if (inject) begin
        if (n == 3) begin wr_en = 1'b1; wr_addr = {blk ^ 4'h5, 2'd1}; wr_data = 32'hDEAD_BEEF; end
        if (n == 4) wr_en = 1'b0;
        if (n == 5) begin req_valid = 1'b1; req_blk = blk ^ 4'hA; end
        if (n == 6) req_valid = 1'b0;
      end
    end
    for (int i = 0; i < 3; i++) begin
      check(ok_lat[i], lat_tag(i), $sformatf("inst %0d done cycle (also R11)", i),
            128'(done_n[i]), 128'(lat_of(i)));
      check(ok_busy[i], "R2", $sformatf("inst %0d busy window", i), 128'(busy_w[i]), 128'd0);
      check(ok_str[i], (i == 1) ? "R10" : "R7",
            $sformatf("inst %0d strobe pattern", i), 128'(done_n[i]), 128'(lat_of(i)));
      check(ok_data[i], dtag, $sformatf("inst %0d block %0d data", i, blk), bad_act[i], bad_exp[i]);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; req_valid = 1'b0; req_blk = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++)
      check(!busy_w[i] && !done_w[i] && !rv_w[i] && !bv_w[i], "R1",
            $sformatf("inst %0d reset outputs", i),
            {busy_w[i], done_w[i], rv_w[i], bv_w[i]}, 128'd0);

    for (int a = 0; a < 64; a++) write_word(6'(a), $urandom());

    // Directed boundary blocks
    refill(4'd0, 1'b0, "R8");
    refill(4'd15, 1'b0, "R8");

    // Request and write during a refill are ignored
    refill(4'd3, 1'b1, "R8");
    repeat (5) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++)
        check(!busy_w[i] && !rv_w[i] && !bv_w[i] && !done_w[i], "R3",
              $sformatf("inst %0d stays idle after ignored request", i),
              {busy_w[i], rv_w[i], bv_w[i], done_w[i]}, 128'd0);
    end
    refill(4'd3 ^ 4'h5, 1'b0, "R9");

    // Idle write then read back
    write_word({4'd9, 2'd2}, 32'h1234_5678);
    refill(4'd9, 1'b0, "R9");

    // Random traffic
    for (int t = 0; t < 8; t++) begin
      logic [3:0] b;
      b = 4'($urandom_range(0, 15));
      write_word({b, 2'($urandom_range(0, 3))}, $urandom());
      refill(b, 1'b0, "R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule